// File: doc/BRIEF.md
# Boundary Scan Test Access Unit

This block is a serial test port that follows the IEEE 1149.1 model. Test clock, mode select and an asynchronous active-low test reset drive a sixteen-state controller. The controller steps a three-bit instruction register and one of two data paths between serial in and serial out. The instruction register has a serial stage and a parallel stage. The data paths are a one-bit bypass register and a boundary chain of capture, shift and update cells. The chain has 132 cells by default and is parameterized by region.

The boundary chain has three regions. Input-pin cells sit nearest the serial output, followed by pad-output cells and then output-enable cells. With the external-test instruction, the update stage drives the pad outputs and enables, and a reset request goes to the system logic. With any other instruction, the functional path drives the pads. The high-impedance instruction turns every enable off. At instruction capture, a crystal-loss status flag is loaded into the top bit of the instruction register, so a tester can read it.

Top module: `jtag_tap_unit`

## Requirements
- R1: Driving `trst_n` low puts the controller in Test-Logic-Reset at once, without a clock. The active instruction becomes 3'b111, which selects the bypass path.
- R2: Five TCK rising edges with `tms`=1 bring the controller to Test-Logic-Reset from any state. This restores the bypass instruction.
- R3: In Capture-IR the serial stage loads `{xtal_lost,1'b0,1'b1}`. Shift-IR then sends this value out on `tdo`, bit 0 first.
- R4: The active instruction changes only on the rising edge in Update-IR (or in Test-Logic-Reset). Shifting a new code has no effect on the outputs before that edge.
- R5: Codes 3'b000 (external test) and 3'b001 (sample/preload) place the boundary chain between `tdi` and `tdo`. Chain bit 0 is `pin_in[0]`, the bits above it are `pin_in`, then `pin_out`, then `pin_oe`, and bit 0 leaves first.
- R6: Codes 3'b010, 3'b011, 3'b101, 3'b110 and 3'b111 select the one-bit bypass register. This register captures 0 in Capture-DR.
- R7: Code 3'b100 (high impedance) forces every `pin_oe` bit to 0 and selects the bypass register.
- R8: While code 3'b000 is active, `sys_rst_req` is 1 and `pin_out`/`pin_oe` come from the boundary update stage. Under any other code, `sys_rst_req` is 0 and `pin_out` follows `func_out`. Under any other code except 3'b100, `pin_oe` follows `func_oe`.
- R9: In Capture-DR the boundary chain captures `pin_in` and the driven `pin_out`/`pin_oe` values. In Update-DR it copies the shifted data into the update stage; this works under sample/preload too.
- R10: `tdo` changes only on the falling edge of TCK. `tdo_en` is 1 only while the controller is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| xtal_lost | input | 1 | 1 when no clock is seen from the crystal source |
| pin_in | input | NUM_IN | Values seen at the input pins |
| func_out | input | NUM_OUT | Functional values for the output pads |
| func_oe | input | NUM_OE | Functional output enables, 1 = drive |
| pin_out | output | NUM_OUT | Values driven to the output pads |
| pin_oe | output | NUM_OE | Enables driven to the pads |
| sys_rst_req | output | 1 | Reset request to the system logic |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Marks `tdo` as valid |

## Verification
The data path is tried with short patterns through bypass. Here a single leading zero followed by the delayed input shows a one-bit path and no longer one. Full-length patterns go through the boundary chain, and the captured word shows which region feeds which bits. A preload pattern is scanned in under sample/preload and then made active with external test: the pads must stay on the functional values until the instruction update and take the pattern afterwards. This separates the shift, update and instruction-update stages. Every code that is not external test, sample/preload or high impedance is scanned with the same bypass pattern. Capture-IR is read with the crystal flag both low and high, so a swapped bit position or a stuck flag shows up.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

   localparam int IR_W = 3;

   localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
   localparam logic [IR_W-1:0] OP_SAMPLE = 3'b001;
   localparam logic [IR_W-1:0] OP_HIZ    = 3'b100;
   localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

   typedef enum logic [3:0] {
      S_TLR, S_RTI,
      S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
      S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
   } tap_state_e;

   typedef struct packed {
      logic extest;
      logic sample;
      logic hiz;
      logic bypass;
   } ir_dec_t;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      case (s)
         S_TLR:    return m ? S_TLR    : S_RTI;
         S_RTI:    return m ? S_SEL_DR : S_RTI;
         S_SEL_DR: return m ? S_SEL_IR : S_CAP_DR;
         S_CAP_DR: return m ? S_EX1_DR : S_SH_DR;
         S_SH_DR:  return m ? S_EX1_DR : S_SH_DR;
         S_EX1_DR: return m ? S_UPD_DR : S_PAU_DR;
         S_PAU_DR: return m ? S_EX2_DR : S_PAU_DR;
         S_EX2_DR: return m ? S_UPD_DR : S_SH_DR;
         S_UPD_DR: return m ? S_SEL_DR : S_RTI;
         S_SEL_IR: return m ? S_TLR    : S_CAP_IR;
         S_CAP_IR: return m ? S_EX1_IR : S_SH_IR;
         S_SH_IR:  return m ? S_EX1_IR : S_SH_IR;
         S_EX1_IR: return m ? S_UPD_IR : S_PAU_IR;
         S_PAU_IR: return m ? S_EX2_IR : S_PAU_IR;
         S_EX2_IR: return m ? S_UPD_IR : S_SH_IR;
         S_UPD_IR: return m ? S_SEL_DR : S_RTI;
         default:  return S_TLR;
      endcase
   endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
   import jtag_tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= S_TLR;
      else         state <= tap_next(state, tms);
   end

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
   import jtag_tap_pkg::*;
(
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   input  logic            xtal_lost,
   output logic            so,
   output logic [IR_W-1:0] hold
);

   localparam logic [IR_W-2:0] CAP_LOW = {{(IR_W-3){1'b0}}, 2'b01};

   logic [IR_W-1:0] sr_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sr_q <= OP_BYPASS;
         hold <= OP_BYPASS;
      end else begin
         case (state)
            S_CAP_IR: sr_q <= {xtal_lost, CAP_LOW};
            S_SH_IR:  sr_q <= {tdi, sr_q[IR_W-1:1]};
            default:  sr_q <= sr_q;
         endcase
         if (state == S_TLR)          hold <= OP_BYPASS;
         else if (state == S_UPD_IR)  hold <= sr_q;
      end
   end

   assign so = sr_q[0];

endmodule

// File: rtl/jtag_tap_dec.sv
module jtag_tap_dec
   import jtag_tap_pkg::*;
(
   input  logic [IR_W-1:0] code,
   output ir_dec_t         dec
);

   always_comb begin
      dec = '0;
      case (code)
         OP_EXTEST: dec.extest = 1'b1;
         OP_SAMPLE: dec.sample = 1'b1;
         OP_HIZ:    dec.hiz    = 1'b1;
         default:   dec.bypass = 1'b1;
      endcase
   end

endmodule

// File: rtl/jtag_tap_bsr.sv
module jtag_tap_bsr #(
   parameter int LEN = 132
) (
   input  logic           tck,
   input  logic           trst_n,
   input  logic           cap_en,
   input  logic           sh_en,
   input  logic           upd_en,
   input  logic           tdi,
   input  logic [LEN-1:0] cap_vec,
   output logic           so,
   output logic [LEN-1:0] upd_vec
);

   logic [LEN-1:0] sh_q;
   logic [LEN-1:0] nxt;

   for (genvar i = 0; i < LEN; i++) begin : g_cell
      if (i == LEN - 1) begin : g_head
         assign nxt[i] = tdi;
      end else begin : g_body
         assign nxt[i] = sh_q[i+1];
      end

      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n) begin
            sh_q[i]    <= 1'b0;
            upd_vec[i] <= 1'b0;
         end else begin
            if (cap_en)     sh_q[i] <= cap_vec[i];
            else if (sh_en) sh_q[i] <= nxt[i];
            if (upd_en)     upd_vec[i] <= sh_q[i];
         end
      end
   end

   assign so = sh_q[0];

endmodule

// File: rtl/jtag_tap_unit.sv
module jtag_tap_unit
   import jtag_tap_pkg::*;
#(
   parameter int NUM_IN      = 100,
   parameter int NUM_OUT     = 24,
   parameter int NUM_OE      = 8,
   parameter bit TDO_ON_FALL = 1'b1
) (
   input  logic               tck,
   input  logic               tms,
   input  logic               trst_n,
   input  logic               tdi,
   input  logic               xtal_lost,
   input  logic [NUM_IN-1:0]  pin_in,
   input  logic [NUM_OUT-1:0] func_out,
   input  logic [NUM_OE-1:0]  func_oe,
   output logic [NUM_OUT-1:0] pin_out,
   output logic [NUM_OE-1:0]  pin_oe,
   output logic               sys_rst_req,
   output logic               tdo,
   output logic               tdo_en
);

   localparam int LEN    = NUM_IN + NUM_OUT + NUM_OE;
   localparam int OUT_LO = NUM_IN;
   localparam int OE_LO  = NUM_IN + NUM_OUT;

   if (NUM_IN < 1)  begin : g_bad_in  $error("NUM_IN must be at least 1");  end
   if (NUM_OUT < 1) begin : g_bad_out $error("NUM_OUT must be at least 1"); end
   if (NUM_OE < 1)  begin : g_bad_oe  $error("NUM_OE must be at least 1");  end

   tap_state_e      state_q;
   logic            ir_so;
   logic [IR_W-1:0] ir_hold;
   ir_dec_t         dec;
   logic            bsr_so;
   logic [LEN-1:0]  upd_vec;
   logic [LEN-1:0]  cap_vec;
   logic            bsr_sel;
   logic            byp_q;
   logic            dr_so;
   logic            tdo_d;
   logic            in_shift;

   jtag_tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (state_q)
   );

   jtag_tap_ir u_ir (
      .tck       (tck),
      .trst_n    (trst_n),
      .state     (state_q),
      .tdi       (tdi),
      .xtal_lost (xtal_lost),
      .so        (ir_so),
      .hold      (ir_hold)
   );

   jtag_tap_dec u_dec (
      .code (ir_hold),
      .dec  (dec)
   );

   assign bsr_sel = dec.extest | dec.sample;
   assign cap_vec = {pin_oe, pin_out, pin_in};

   jtag_tap_bsr #(.LEN(LEN)) u_bsr (
      .tck     (tck),
      .trst_n  (trst_n),
      .cap_en  (bsr_sel && state_q == S_CAP_DR),
      .sh_en   (bsr_sel && state_q == S_SH_DR),
      .upd_en  (bsr_sel && state_q == S_UPD_DR),
      .tdi     (tdi),
      .cap_vec (cap_vec),
      .so      (bsr_so),
      .upd_vec (upd_vec)
   );

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                 byp_q <= 1'b0;
      else if (state_q == S_CAP_DR) byp_q <= 1'b0;
      else if (state_q == S_SH_DR)  byp_q <= tdi;
   end

   assign dr_so    = (dec.bypass | dec.hiz) ? byp_q : bsr_so;
   assign in_shift = (state_q == S_SH_IR) || (state_q == S_SH_DR);
   assign tdo_d    = (state_q == S_SH_IR) ? ir_so : dr_so;

   if (TDO_ON_FALL) begin : g_tdo_fall
      always_ff @(negedge tck or negedge trst_n) begin
         if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
         end else begin
            tdo    <= tdo_d;
            tdo_en <= in_shift;
         end
      end
   end else begin : g_tdo_rise
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
         end else begin
            tdo    <= tdo_d;
            tdo_en <= in_shift;
         end
      end
   end

   assign sys_rst_req = dec.extest;
   assign pin_out = dec.extest ? upd_vec[OE_LO-1:OUT_LO] : func_out;
   assign pin_oe  = dec.hiz    ? '0
                  : dec.extest ? upd_vec[LEN-1:OE_LO]    : func_oe;

endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
   import jtag_tap_pkg::*;
#(
   parameter int NUM_OE = 8
) (
   input logic              tck,
   input logic              trst_n,
   input logic              tms,
   input tap_state_e        state,
   input logic [IR_W-1:0]   ir_hold,
   input logic              tdo_en,
   input logic              sys_rst_req,
   input logic [NUM_OE-1:0] pin_oe
);

   AST_TLR_PRESET: assert property (@(posedge tck) disable iff (!trst_n)
      (state == S_TLR) |=> (ir_hold == OP_BYPASS)); // R1

   AST_TLR_HOLDS: assert property (@(posedge tck) disable iff (!trst_n)
      (state == S_TLR && tms) |=> (state == S_TLR)); // R2

   AST_IR_STABLE: assert property (@(posedge tck) disable iff (!trst_n)
      (state != S_UPD_IR && state != S_TLR) |=> $stable(ir_hold)); // R4

   AST_HIZ_OE_OFF: assert property (@(posedge tck) disable iff (!trst_n)
      (ir_hold == OP_HIZ) |-> (pin_oe == '0)); // R7

   AST_EXTEST_RST: assert property (@(posedge tck) disable iff (!trst_n)
      (ir_hold == OP_EXTEST) |-> sys_rst_req); // R8

   AST_OTHER_NO_RST: assert property (@(posedge tck) disable iff (!trst_n)
      (ir_hold != OP_EXTEST) |-> !sys_rst_req); // R8

   AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en |-> (state == S_SH_DR || state == S_SH_IR)); // R10

endmodule

bind jtag_tap_unit jtag_tap_chk #(.NUM_OE(NUM_OE)) u_chk (
   .tck         (tck),
   .trst_n      (trst_n),
   .tms         (tms),
   .state       (state_q),
   .ir_hold     (ir_hold),
   .tdo_en      (tdo_en),
   .sys_rst_req (sys_rst_req),
   .pin_oe      (pin_oe)
);

// File: tb/jtag_tap_unit_tb_top.sv
`timescale 1ns/1ps
module jtag_tap_unit_tb_top;

   localparam int NI  = 100;
   localparam int NO  = 24;
   localparam int NE  = 8;
   localparam int LEN = NI + NO + NE;

   logic          tck = 1'b0;
   logic          tms = 1'b1;
   logic          trst_n = 1'b0;
   logic          tdi = 1'b0;
   logic          xtal_lost = 1'b0;
   logic [NI-1:0] pin_in = '0;
   logic [NO-1:0] func_out = '0;
   logic [NE-1:0] func_oe = '0;
   logic [NO-1:0] pin_out;
   logic [NE-1:0] pin_oe;
   logic          sys_rst_req;
   logic          tdo;
   logic          tdo_en;

   int n_chk = 0;
   int n_fail = 0;
   int tdo_moves = 0;
   int en_bad = 0;
   logic ir_pre_rst;

   always #2 tck = ~tck;

   jtag_tap_unit dut_i (
      .tck(tck), .tms(tms), .trst_n(trst_n), .tdi(tdi), .xtal_lost(xtal_lost),
      .pin_in(pin_in), .func_out(func_out), .func_oe(func_oe),
      .pin_out(pin_out), .pin_oe(pin_oe), .sys_rst_req(sys_rst_req),
      .tdo(tdo), .tdo_en(tdo_en)
   );

   task automatic chk(input string req, input logic [LEN-1:0] act, input logic [LEN-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d, output logic so);
      logic pre;
      @(negedge tck);
      #1;
      so  = tdo;
      tms = m;
      tdi = d;
      pre = tdo;
      @(posedge tck);
      #1;
      if (tdo !== pre) tdo_moves++;
   endtask

   task automatic scan_dr(input int n, input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
      logic s;
      dout = '0;
      tick(1, 0, s); tick(0, 0, s); tick(0, 0, s);
      for (int i = 0; i < n; i++) begin
         tick(i == n - 1, din[i], s);
         dout[i] = s;
         if (tdo_en !== 1'b1) en_bad++;
      end
      tick(1, 0, s); tick(0, 0, s);
   endtask

   task automatic scan_ir(input logic [2:0] din, output logic [2:0] dout);
      logic s;
      tick(1, 0, s); tick(1, 0, s); tick(0, 0, s); tick(0, 0, s);
      for (int i = 0; i < 3; i++) begin
         tick(i == 2, din[i], s);
         dout[i] = s;
         if (tdo_en !== 1'b1) en_bad++;
      end
      ir_pre_rst = sys_rst_req;
      tick(1, 0, s); tick(0, 0, s);
   endtask

   task automatic t_reset;
      chk("R1 sys_rst_req after reset", LEN'(sys_rst_req), '0);
      chk("R1 tdo_en after reset", LEN'(tdo_en), '0);
      chk("R8 pin_out functional after reset", LEN'(pin_out), LEN'(func_out));
      chk("R8 pin_oe functional after reset", LEN'(pin_oe), LEN'(func_oe));
   endtask

   task automatic t_bypass_len(input string req);
      logic [LEN-1:0] o;
      scan_dr(6, LEN'(6'b101101), o);
      chk(req, o, LEN'(7'b1011010) & LEN'(6'h3F));
   endtask

   task automatic t_ir_capture;
      logic [2:0] o;
      xtal_lost = 1'b1;
      scan_ir(3'b111, o);
      chk("R3 capture with crystal flag 1", LEN'(o), LEN'(3'b101));
      xtal_lost = 1'b0;
      scan_ir(3'b111, o);
      chk("R3 capture with crystal flag 0", LEN'(o), LEN'(3'b001));
   endtask

   task automatic t_sample_preload;
      logic [2:0] o;
      logic [LEN-1:0] d;
      logic [LEN-1:0] p;
      p = {8'h3C, 24'hC3A55A, 4'h6, 32'h0F1E2D3C, 32'h4B5A6978, 32'h8796A5B4};
      scan_ir(3'b001, o);
      chk("R8 no reset under sample", LEN'(sys_rst_req), '0);
      scan_dr(LEN, '0, d);
      chk("R9 R5 sample capture word", d, {func_oe, func_out, pin_in});
      scan_dr(LEN, p, d);
      chk("R8 pins functional after preload", LEN'({pin_oe, pin_out}), LEN'({func_oe, func_out}));
      scan_ir(3'b000, o);
      chk("R4 no reset before Update-IR", LEN'(ir_pre_rst), '0);
      chk("R8 reset request under extest", LEN'(sys_rst_req), LEN'(1));
      chk("R9 R8 preloaded pads under extest", LEN'({pin_oe, pin_out}), LEN'(p[LEN-1:NI]));
      scan_dr(LEN, '0, d);
      chk("R5 R9 extest capture of driven pads", d, {p[LEN-1:NI], pin_in});
      chk("R9 update stage latched zeros", LEN'({pin_oe, pin_out}), '0);
   endtask

   task automatic t_tms_reset;
      logic s;
      logic [2:0] o;
      logic [LEN-1:0] d;
      scan_ir(3'b000, o);
      tick(1, 0, s); tick(1, 0, s); tick(0, 0, s);
      for (int i = 0; i < 5; i++) tick(1, 0, s);
      chk("R2 five TMS highs clear extest", LEN'(sys_rst_req), '0);
      chk("R2 pads back to functional", LEN'(pin_out), LEN'(func_out));
      tick(0, 0, s);
      scan_dr(6, LEN'(6'b101101), d);
      chk("R2 bypass after TMS reset", d, LEN'(6'b011010));
   endtask

   task automatic t_hiz;
      logic [2:0] o;
      logic [LEN-1:0] d;
      scan_ir(3'b100, o);
      chk("R7 enables off under hi-z", LEN'(pin_oe), '0);
      chk("R7 pad outputs functional under hi-z", LEN'(pin_out), LEN'(func_out));
      scan_dr(6, LEN'(6'b110011), d);
      chk("R7 hi-z selects bypass", d, LEN'(6'b100110));
   endtask

   task automatic t_bypass_codes;
      logic [2:0] o;
      logic [LEN-1:0] d;
      for (int k = 0; k < 8; k++) begin
         if (k != 0 && k != 1 && k != 4) begin
            scan_ir(3'(k), o);
            scan_dr(6, LEN'(6'b111011), d);
            chk($sformatf("R6 code %0d bypass", k), d, LEN'(6'b110110));
            chk($sformatf("R6 code %0d pads functional", k), LEN'({pin_oe, pin_out}), LEN'({func_oe, func_out}));
         end
      end
   endtask

   task automatic t_async_trst;
      logic [2:0] o;
      logic s;
      scan_ir(3'b000, o);
      chk("R1 extest loaded before async reset", LEN'(sys_rst_req), LEN'(1));
      @(negedge tck);
      #0.5;
      trst_n = 1'b0;
      #0.5;
      chk("R1 async reset clears instruction", LEN'(sys_rst_req), '0);
      #1;
      trst_n = 1'b1;
      tms = 1'b1;
      tick(0, 0, s);
   endtask

   initial begin
      #800000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic s;
      pin_in   = {4'h9, 32'hA5C31E97, 32'h5B2D7F04, 32'h3E81C6A9};
      func_out = 24'h5A0F3C;
      func_oe  = 8'h96;
      #10;
      t_reset();
      trst_n = 1'b1;
      tick(0, 0, s);
      t_bypass_len("R1 R6 bypass after reset");
      t_ir_capture();
      t_sample_preload();
      t_tms_reset();
      t_hiz();
      t_bypass_codes();
      t_async_trst();
      chk("R10 tdo_en low outside shift", LEN'(tdo_en), '0);
      chk("R10 tdo_en high in every shift bit", LEN'(en_bad), '0);
      chk("R10 tdo steady across rising edges", LEN'(tdo_moves), '0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule